// File: doc/BRIEF.md
# Next Program Counter Unit

This block keeps the 32-bit program counter of a simple processor and selects its next value every clock. Each cycle it receives the instruction word currently being executed, a single flag that says whether the two register operands compare equal, and the 32-bit register value used by register-indirect jumps. From these it picks one of four successors: the sequential address, a PC-relative branch target, a region-relative absolute jump target, or the register value.

Branch targets are computed from the address of the following instruction. The 16-bit offset counts words, so it is scaled by four and sign-extended. Jump targets keep the top four bits of the following-instruction address and fill the rest from the 26-bit field of the instruction, scaled by four. A register jump to an address that is not word-aligned is refused. The block raises a fault flag in the same cycle and the counter keeps its value. The block also drives the current address and the current address plus four, which serves as the fetch address and as a link value.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_cur` holds the parameter `START_ADDR` (default 0x00400000) and `pc_plus4` equals `START_ADDR + 4`.
- R2: For any instruction that is not a branch, jump or register jump, `pc_cur` becomes the old `pc_cur + 4` at the next rising clock edge. This includes opcode 0 with a function code other than 0x08. The opcode is `instr_word[31:26]` and the function code is `instr_word[5:0]`.
- R3: Opcode 4 is branch-if-equal. When `ops_equal` is 1 the next PC is the branch target. When it is 0 the next PC is `pc_cur + 4`.
- R4: Opcode 5 is branch-if-not-equal. When `ops_equal` is 0 the next PC is the branch target. When it is 1 the next PC is `pc_cur + 4`.
- R5: The branch target is `(pc_cur + 4)` plus the offset in `instr_word[15:0]`, shifted left by two and sign-extended from 18 bits. Offsets 0x7FFF and 0x8000 give the furthest forward and backward reach.
- R6: Opcode 2 is an unconditional jump. The next PC is `{(pc_cur+4)[31:28], instr_word[25:0], 2'b00}`, so the region comes from the following-instruction address even when that address wraps.
- R7: Opcode 0 with function code 0x08 is a register jump. When `jr_value[1:0]` is 0, the next PC is `jr_value`.
- R8: A register jump with `jr_value[1:0]` not 0 drives `align_fault` to 1 in the same cycle, and `pc_cur` keeps its value. `align_fault` is 0 for every other instruction, whatever the value of `jr_value`.
- R9: `pc_plus4` always equals `pc_cur + 4` modulo 2^32, wrapping from 0xFFFFFFFC to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| instr_word | input | 32 | Instruction currently being executed |
| ops_equal | input | 1 | 1 when the two register operands are equal |
| jr_value | input | 32 | Register operand for register jumps |
| pc_cur | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus four |
| align_fault | output | 1 | Misaligned register-jump target, PC held |

## Verification
On every cycle the assertions check several relations. A sequential or untaken step moves the counter by exactly four. A taken jump keeps the region bits of the following-instruction address. An aligned register jump lands on the register value. A fault occurs only on a register jump and freezes the counter. The counter stays word-aligned. Only the directed scenarios can show the exact arithmetic of targets for particular inputs: the worked jump and branch addresses, the extreme forward and backward offsets, region selection at the top of the address space, and the reset value.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int PC_W     = 32;
  localparam int OPC_W    = 6;
  localparam int FUNCT_W  = 6;
  localparam int IMM_W    = 16;
  localparam int JFIELD_W = 26;
  localparam int ALIGN_W  = 2;
  localparam int REGION_W = PC_W - JFIELD_W - ALIGN_W;
  localparam int BEXT_W   = PC_W - IMM_W - ALIGN_W;

  localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0]   OPC_JUMP    = 6'd2;
  localparam logic [OPC_W-1:0]   OPC_BREQ    = 6'd4;
  localparam logic [OPC_W-1:0]   OPC_BRNE    = 6'd5;
  localparam logic [FUNCT_W-1:0] FN_JREG     = 6'h08;

  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2,
    NPC_JREG   = 2'd3
  } npc_sel_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FUNCT_W-1:0] funct,
  input  logic               ops_equal,
  output npc_sel_e           sel
);
  always_comb begin
    sel = NPC_SEQ;
    unique case (opcode)
      OPC_BREQ:    sel = ops_equal  ? NPC_BRANCH : NPC_SEQ;
      OPC_BRNE:    sel = !ops_equal ? NPC_BRANCH : NPC_SEQ;
      OPC_JUMP:    sel = NPC_JUMP;
      OPC_SPECIAL: sel = (funct == FN_JREG) ? NPC_JREG : NPC_SEQ;
      default:     sel = NPC_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [PC_W-1:0]     seq_addr,
  input  logic [JFIELD_W-1:0] jfield,
  input  logic [PC_W-1:0]     jr_value,
  output logic [PC_W-1:0]     br_tgt,
  output logic [PC_W-1:0]     jmp_tgt,
  output logic                jr_misaligned
);
  logic [IMM_W-1:0] imm;
  logic [PC_W-1:0]  br_off;

  always_comb begin
    imm           = jfield[IMM_W-1:0];
    br_off        = {{BEXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
    br_tgt        = seq_addr + br_off;
    jmp_tgt       = {seq_addr[PC_W-1 -: REGION_W], jfield, {ALIGN_W{1'b0}}};
    jr_misaligned = |jr_value[ALIGN_W-1:0];
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
  import npc_pkg::*;
#(
  parameter logic [PC_W-1:0] START_ADDR = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);
  logic [PC_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= START_ADDR;
    else        q <= q_nxt;
  end

  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> q == $past(q)); // R8
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [PC_W-1:0] START_ADDR = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] instr_word,
  input  logic            ops_equal,
  input  logic [PC_W-1:0] jr_value,
  output logic [PC_W-1:0] pc_cur,
  output logic [PC_W-1:0] pc_plus4,
  output logic            align_fault
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [OPC_W-1:0]    opcode;
  logic [FUNCT_W-1:0]  funct;
  logic [JFIELD_W-1:0] jfield;
  npc_sel_e            sel;
  logic [PC_W-1:0]     br_tgt, jmp_tgt, pc_nxt;
  logic                jr_misaligned, load_en;

  assign opcode = instr_word[PC_W-1 -: OPC_W];
  assign funct  = instr_word[FUNCT_W-1:0];
  assign jfield = instr_word[JFIELD_W-1:0];

  npc_decode u_decode (
    .opcode    (opcode),
    .funct     (funct),
    .ops_equal (ops_equal),
    .sel       (sel)
  );

  npc_target u_target (
    .seq_addr      (pc_plus4),
    .jfield        (jfield),
    .jr_value      (jr_value),
    .br_tgt        (br_tgt),
    .jmp_tgt       (jmp_tgt),
    .jr_misaligned (jr_misaligned)
  );

  always_comb begin
    pc_plus4 = pc_cur + STEP;
    unique case (sel)
      NPC_BRANCH: pc_nxt = br_tgt;
      NPC_JUMP:   pc_nxt = jmp_tgt;
      NPC_JREG:   pc_nxt = jr_value;
      default:    pc_nxt = pc_plus4;
    endcase
    align_fault = (sel == NPC_JREG) && jr_misaligned;
    load_en     = !align_fault;
  end

  npc_pc_reg #(.START_ADDR(START_ADDR)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .d       (pc_nxt),
    .q       (pc_cur)
  );

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == NPC_SEQ) |=> pc_cur == $past(pc_cur) + STEP); // R2
  AST_BREQ_UNTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_BREQ && !ops_equal) |=> pc_cur == $past(pc_cur) + STEP); // R3
  AST_BRNE_UNTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_BRNE && ops_equal) |=> pc_cur == $past(pc_cur) + STEP); // R4
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc_cur[ALIGN_W-1:0] == '0); // R5
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_JUMP) |=>
      pc_cur[PC_W-1 -: REGION_W] == $past(pc_plus4[PC_W-1 -: REGION_W])); // R6
  AST_JREG_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_SPECIAL && funct == FN_JREG && jr_value[ALIGN_W-1:0] == '0)
      |=> pc_cur == $past(jr_value)); // R7
  AST_FAULT_ONLY_JREG: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> (opcode == OPC_SPECIAL && funct == FN_JREG)); // R8
  AST_FAULT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |=> $stable(pc_cur)); // R8
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] START = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_word = 32'h0;
  logic        ops_equal = 1'b0;
  logic [31:0] jr_value = 32'h0;
  logic [31:0] pc_cur, pc_plus4;
  logic        align_fault;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  npc_unit #(.START_ADDR(START)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .ops_equal(ops_equal),
    .jr_value(jr_value), .pc_cur(pc_cur), .pc_plus4(pc_plus4),
    .align_fault(align_fault)
  );

  function automatic logic [31:0] enc_branch(input logic [5:0] opc, input logic [15:0] off);
    return {opc, 5'd16, 5'd17, off};
  endfunction
  function automatic logic [31:0] enc_jump(input logic [25:0] fld);
    return {6'd2, fld};
  endfunction
  localparam logic [31:0] JR_T1  = {6'd0, 5'd9, 15'd0, 6'h08};
  localparam logic [31:0] ADD_OP = {6'd0, 5'd16, 5'd17, 5'd19, 5'd0, 6'h20};
  localparam logic [31:0] LW_OP  = {6'h23, 5'd18, 5'd8, 16'd100};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] iw, input logic eq, input logic [31:0] rv);
    instr_word = iw; ops_equal = eq; jr_value = rv;
    @(posedge clk); #1;
  endtask

  task automatic place_pc(input logic [31:0] a);
    step(JR_T1, 1'b0, a);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #1;
    check("R1 reset pc", pc_cur, START);
    check("R9 reset plus4", pc_plus4, START + 32'd4);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic t_sequential;
    logic [31:0] p;
    p = pc_cur;
    step(ADD_OP, 1'b1, 32'h3);
    check("R2 add advances", pc_cur, p + 32'd4);
    step(LW_OP, 1'b0, 32'h0);
    check("R2 load advances", pc_cur, p + 32'd8);
    step({6'd0, 20'd0, 6'h2a}, 1'b0, 32'h0);
    check("R2 other funct advances", pc_cur, p + 32'd12);
  endtask

  task automatic t_beq;
    place_pc(32'h0040_0020);
    step(enc_branch(6'd4, 16'd2), 1'b1, 32'h0);
    check("R3 beq taken", pc_cur, 32'h0040_002C);
    place_pc(32'h0040_0020);
    step(enc_branch(6'd4, 16'd2), 1'b0, 32'h0);
    check("R3 beq untaken", pc_cur, 32'h0040_0024);
  endtask

  task automatic t_bne;
    place_pc(32'h0040_0040);
    step(enc_branch(6'd5, 16'd3), 1'b0, 32'h0);
    check("R4 bne taken", pc_cur, 32'h0040_0050);
    place_pc(32'h0040_0040);
    step(enc_branch(6'd5, 16'd3), 1'b1, 32'h0);
    check("R4 bne untaken", pc_cur, 32'h0040_0044);
  endtask

  task automatic t_offsets;
    place_pc(32'h0040_0100);
    step(enc_branch(6'd4, 16'hFFFE), 1'b1, 32'h0);
    check("R5 backward offset", pc_cur, 32'h0040_00FC);
    place_pc(32'h0040_0000);
    step(enc_branch(6'd4, 16'h7FFF), 1'b1, 32'h0);
    check("R5 max forward", pc_cur, 32'h0042_0000);
    place_pc(32'h0044_0000);
    step(enc_branch(6'd5, 16'h8000), 1'b0, 32'h0);
    check("R5 max backward", pc_cur, 32'h0042_0004);
  endtask

  task automatic t_jump;
    place_pc(32'h0040_0028);
    step(enc_jump(26'h0100003), 1'b0, 32'h0);
    check("R6 jump example", pc_cur, 32'h0040_000C);
    place_pc(32'hA000_0010);
    step(enc_jump(26'h3FFFFFF), 1'b1, 32'h0);
    check("R6 jump region", pc_cur, 32'hAFFF_FFFC);
    place_pc(32'hFFFF_FFFC);
    step(enc_jump(26'h0000001), 1'b0, 32'h0);
    check("R6 jump region wraps", pc_cur, 32'h0000_0004);
  endtask

  task automatic t_jreg;
    step(JR_T1, 1'b0, 32'h1234_5678);
    check("R7 jr lands", pc_cur, 32'h1234_5678);
    instr_word = JR_T1; jr_value = 32'h0000_1002; #1;
    check("R8 fault raised", {31'd0, align_fault}, 32'd1);
    @(posedge clk); #1;
    check("R8 pc held", pc_cur, 32'h1234_5678);
    instr_word = ADD_OP; jr_value = 32'h0000_1003; #1;
    check("R8 no fault non-jr", {31'd0, align_fault}, 32'd0);
    @(posedge clk); #1;
    check("R8 non-jr advances", pc_cur, 32'h1234_567C);
    instr_word = JR_T1; jr_value = 32'h0000_2000; #1;
    check("R8 no fault aligned jr", {31'd0, align_fault}, 32'd0);
    @(posedge clk); #1;
  endtask

  task automatic t_wrap;
    place_pc(32'hFFFF_FFFC);
    check("R9 plus4 wraps", pc_plus4, 32'h0);
    step(ADD_OP, 1'b0, 32'h0);
    check("R9 pc wraps", pc_cur, 32'h0);
    check("R9 plus4 after wrap", pc_plus4, 32'h4);
  endtask

  initial begin
    #(CLK_PERIOD/2 + 1);
    t_reset();
    t_sequential();
    t_beq();
    t_bne();
    t_offsets();
    t_jump();
    t_jreg();
    t_wrap();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule